// File: doc/BRIEF.md
# Slotted Bit-Field Move Unit

This unit moves contiguous bit fields between words. A small bank of descriptor slots holds field definitions, each an offset and a length. When a slot is written, the unit computes and stores the field mask and the width after truncation. Each data operation names a slot and applies one of four operations to a destination word and a source word:

- insert a field into a word;
- extract a field, zero-extended;
- extract a field and rotate it in from the left;
- extract a field and rotate it in from the right.

Each operation produces one registered result. Independent tasks can keep separate field definitions in separate slots, so a task does not need to reconfigure the unit before each use.

The result stage is a two-state machine. `ST_IDLE` means no result is presented. `ST_RESULT` means a result is valid for exactly one cycle. The transition `ST_IDLE -> ST_RESULT` or `ST_RESULT -> ST_RESULT` is taken on an accepted operation. The transition `ST_RESULT -> ST_IDLE` or `ST_IDLE -> ST_IDLE` is taken when no operation is accepted.

Top module: `bitfield_unit`

## Requirements
- R1: After reset, `res_valid` is low and `res_data` is zero. Every slot describes a field at offset 0 spanning the full word.
- R2: A configuration writes `cfg_offset` (0 to DATA_W-1) and `cfg_length` to slot `cfg_slot`. A length code of 0 means DATA_W bits, and any other code means that many bits. A field that would extend past the top bit is cut at the top bit.
- R3: Op code 0 (insert) returns the destination with the field bits replaced by the low bits of the source. Bits outside the field are kept.
- R4: Op code 1 (extract) returns the source field shifted down to bit 0. All bits above the field width are zero.
- R5: Op code 2 (rotate-left extract) returns the destination shifted left by the field width, with the extracted field in the low bits.
- R6: Op code 3 (rotate-right extract) returns the destination shifted right by the field width, with the extracted field in the top bits.
- R7: Writing one slot leaves every other slot unchanged.
- R8: `res_valid` is high in the cycle after an accepted operation and only then. `res_data` holds its value while no operation is accepted.
- R9: An operation issued in the same cycle as a configuration of its own slot uses the previous descriptor. An operation issued in the next cycle uses the new descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Write a descriptor this cycle |
| cfg_slot | input | SLOT_W | Descriptor slot to write |
| cfg_offset | input | OFF_W | Field offset |
| cfg_length | input | OFF_W | Field length code (0 = full word) |
| op_valid | input | 1 | Accept an operation this cycle |
| op_code | input | 2 | 0 insert, 1 extract, 2 rotate-left, 3 rotate-right |
| op_slot | input | SLOT_W | Descriptor used by the operation |
| op_dst | input | DATA_W | Destination word |
| op_src | input | DATA_W | Source word |
| res_valid | output | 1 | Result valid |
| res_data | output | DATA_W | Registered result |

## Verification
The bench builds the unit with DATA_W = 8 and four slots. At that width every offset and length code pair (64 in all) can be swept exhaustively, including every truncated field and the full-width length code. Each pair is checked with all four operations on several data patterns, against a bit-by-bit model. Four slots is enough to show that slots are independent, and to show that a configuration and an operation on the same slot in the same cycle see the old descriptor.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

    typedef enum logic [1:0] {
        OP_INSERT  = 2'd0,
        OP_EXTRACT = 2'd1,
        OP_ROTL    = 2'd2,
        OP_ROTR    = 2'd3
    } bf_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } bf_state_e;

endpackage

// File: rtl/bitfield_slot_bank.sv
module bitfield_slot_bank #(
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4,
    localparam int OFF_W    = $clog2(DATA_W),
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int LEN_W    = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic [OFF_W-1:0]  cfg_length,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [OFF_W-1:0]  rd_offset,
    output logic [LEN_W-1:0]  rd_width,
    output logic [DATA_W-1:0] rd_mask
);

    logic [OFF_W-1:0]  off_q   [NUM_SLOTS];
    logic [LEN_W-1:0]  width_q [NUM_SLOTS];
    logic [DATA_W-1:0] mask_q  [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] wr_en;

    logic [LEN_W-1:0]  req_len;
    logic [LEN_W-1:0]  room;
    logic [LEN_W-1:0]  new_width;
    logic [DATA_W:0]   low_ones;
    logic [DATA_W-1:0] new_mask;

    // Length decode, truncation at the top bit and mask build, all at configure time
    always_comb begin
        req_len   = (cfg_length == '0) ? LEN_W'(DATA_W) : {1'b0, cfg_length};
        room      = LEN_W'(DATA_W) - {1'b0, cfg_offset};
        new_width = (req_len > room) ? room : req_len;
        low_ones  = ((DATA_W+1)'(1) << new_width) - (DATA_W+1)'(1);
        new_mask  = low_ones[DATA_W-1:0] << cfg_offset;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_wr_en
        assign wr_en[g] = cfg_valid && (cfg_slot == SLOT_W'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                off_q[i]   <= '0;
                width_q[i] <= LEN_W'(DATA_W);
                mask_q[i]  <= '1;
            end
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (wr_en[i]) begin
                    off_q[i]   <= cfg_offset;
                    width_q[i] <= new_width;
                    mask_q[i]  <= new_mask;
                end
            end
        end
    end

    assign rd_offset = off_q[rd_slot];
    assign rd_width  = width_q[rd_slot];
    assign rd_mask   = mask_q[rd_slot];

endmodule

// File: rtl/bitfield_datapath.sv
module bitfield_datapath
    import bitfield_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W),
    localparam int LEN_W = OFF_W + 1
) (
    input  logic [1:0]        op_code,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic [OFF_W-1:0]  offset,
    input  logic [LEN_W-1:0]  width,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] placed;
    logic [DATA_W-1:0] field;
    logic [DATA_W-1:0] dst_up;
    logic [DATA_W-1:0] dst_down;
    logic [DATA_W-1:0] field_top;

    always_comb begin
        placed    = (src << offset) & mask;
        field     = (src & mask) >> offset;
        dst_up    = dst << width;
        dst_down  = dst >> width;
        field_top = field << (LEN_W'(DATA_W) - width);
        unique case (bf_op_e'(op_code))
            OP_INSERT:  result = (dst & ~mask) | placed;
            OP_EXTRACT: result = field;
            OP_ROTL:    result = dst_up | field;
            OP_ROTR:    result = dst_down | field_top;
            default:    result = '0;
        endcase
    end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bitfield_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4,
    localparam int OFF_W    = $clog2(DATA_W),
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int LEN_W    = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [OFF_W-1:0]  cfg_offset,
    input  logic [OFF_W-1:0]  cfg_length,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [SLOT_W-1:0] op_slot,
    input  logic [DATA_W-1:0] op_dst,
    input  logic [DATA_W-1:0] op_src,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);

    logic [OFF_W-1:0]  sel_offset;
    logic [LEN_W-1:0]  sel_width;
    logic [DATA_W-1:0] sel_mask;
    logic [DATA_W-1:0] dp_result;
    logic [DATA_W-1:0] res_data_q;

    bf_state_e state_q, state_nxt;

    bitfield_slot_bank #(
        .DATA_W   (DATA_W),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_slot  (cfg_slot),
        .cfg_offset(cfg_offset),
        .cfg_length(cfg_length),
        .rd_slot   (op_slot),
        .rd_offset (sel_offset),
        .rd_width  (sel_width),
        .rd_mask   (sel_mask)
    );

    bitfield_datapath #(
        .DATA_W(DATA_W)
    ) u_dp (
        .op_code(op_code),
        .dst    (op_dst),
        .src    (op_src),
        .offset (sel_offset),
        .width  (sel_width),
        .mask   (sel_mask),
        .result (dp_result)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_nxt = op_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nxt = op_valid ? ST_RESULT : ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        res_data_q <= '0;
        else if (op_valid) res_data_q <= dp_result;
    end

    assign res_valid = (state_q == ST_RESULT);
    assign res_data  = res_data_q;

endmodule

// File: rtl/bitfield_unit_chk.sv
module bitfield_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [1:0]        op_code,
    input logic [DATA_W-1:0] op_dst,
    input logic [DATA_W-1:0] op_src,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data
);

    assert_res_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(res_data)));

    assert_extract_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd1 && op_src == '0) |=> (res_data == '0));

    assert_insert_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'd0 && (&op_src) && (&op_dst)) |=> (&res_data));

endmodule

bind bitfield_unit bitfield_unit_chk #(
    .DATA_W   (DATA_W),
    .NUM_SLOTS(NUM_SLOTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_dst   (op_dst),
    .op_src   (op_src),
    .res_valid(res_valid),
    .res_data (res_data)
);

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;

    localparam int W  = 8;
    localparam int NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_valid = 1'b0;
    logic [1:0] cfg_slot = '0;
    logic [2:0] cfg_offset = '0;
    logic [2:0] cfg_length = '0;
    logic       op_valid = 1'b0;
    logic [1:0] op_code = '0;
    logic [1:0] op_slot = '0;
    logic [W-1:0] op_dst = '0;
    logic [W-1:0] op_src = '0;
    logic         res_valid;
    logic [W-1:0] res_data;

    int tests = 0;
    int fails = 0;
    int sh_off [NS];
    int sh_len [NS];

    always #5 clk = ~clk;

    bitfield_unit #(.DATA_W(W), .NUM_SLOTS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_slot(cfg_slot),
        .cfg_offset(cfg_offset), .cfg_length(cfg_length),
        .op_valid(op_valid), .op_code(op_code), .op_slot(op_slot),
        .op_dst(op_dst), .op_src(op_src),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [W-1:0] model(int code, int off, int lenc,
                                           logic [W-1:0] d, logic [W-1:0] s);
        int w;
        logic [W-1:0] fld;
        logic [W-1:0] r;
        int di;
        w = (lenc == 0) ? W : lenc;
        if (off + w > W) w = W - off;
        fld = '0;
        for (int i = 0; i < w; i++) fld[i] = s[off+i];
        di = int'(d);
        case (code)
            0: begin
                r = d;
                for (int i = 0; i < w; i++) r[off+i] = s[i];
            end
            1: r = fld;
            2: r = W'(((di << w) | int'(fld)) & ((1 << W) - 1));
            default: r = W'((di >> w) | (int'(fld) << (W - w)));
        endcase
        return r;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(int code);
        case (code)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic do_cfg(int slot, int off, int lenc);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_slot = 2'(slot);
        cfg_offset = 3'(off); cfg_length = 3'(lenc);
        @(negedge clk);
        cfg_valid = 1'b0;
        sh_off[slot] = off; sh_len[slot] = lenc;
    endtask

    task automatic do_op(int code, int slot, logic [W-1:0] d, logic [W-1:0] s, string req);
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'(code); op_slot = 2'(slot);
        op_dst = d; op_src = s;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8", W'(res_valid), W'(1));
        chk(req, res_data, model(code, sh_off[slot], sh_len[slot], d, s));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] dp [3];
        logic [W-1:0] sp [3];
        logic [W-1:0] held;
        dp[0] = 8'hA5; sp[0] = 8'h3C;
        dp[1] = 8'h00; sp[1] = 8'hFF;
        dp[2] = 8'hFF; sp[2] = 8'h5A;
        for (int i = 0; i < NS; i++) begin sh_off[i] = 0; sh_len[i] = 0; end

        repeat (2) @(negedge clk);
        // R1: reset state
        chk("R1", W'(res_valid), W'(0));
        chk("R1", res_data, W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", W'(res_valid), W'(0));
        // R1: reset descriptors cover the full word
        for (int sl = 0; sl < NS; sl++) begin
            do_op(0, sl, 8'h12, 8'hC7, "R1");
            do_op(1, sl, 8'h00, 8'h96, "R1");
        end

        // R8: hold when idle
        held = res_data;
        @(negedge clk);
        chk("R8", W'(res_valid), W'(0));
        chk("R8", res_data, held);

        // R2..R6: exhaustive offset/length sweep
        for (int off = 0; off < W; off++) begin
            for (int len = 0; len < W; len++) begin
                int sl;
                sl = (off + len) % NS;
                do_cfg(sl, off, len);
                for (int code = 0; code < 4; code++)
                    for (int p = 0; p < 3; p++)
                        do_op(code, sl, dp[p], sp[p], req_of(code));
            end
        end

        // R2: truncation and full-length code spot checks
        do_cfg(0, 6, 5);
        do_op(0, 0, 8'h00, 8'hFF, "R2");
        chk("R2", res_data, 8'hC0);
        do_cfg(0, 0, 0);
        do_op(1, 0, 8'h00, 8'h81, "R2");
        chk("R2", res_data, 8'h81);

        // R7: slot independence
        do_cfg(0, 0, 2);
        do_cfg(1, 2, 3);
        do_cfg(2, 4, 4);
        do_cfg(3, 7, 1);
        do_cfg(1, 5, 2);
        for (int sl = 0; sl < NS; sl++)
            for (int code = 0; code < 4; code++)
                do_op(code, sl, 8'h6B, 8'hD4, "R7");

        // R9: same-cycle configure sees old descriptor, next cycle sees new
        @(negedge clk);
        cfg_valid = 1'b1; cfg_slot = 2'd2; cfg_offset = 3'd1; cfg_length = 3'd3;
        op_valid = 1'b1; op_code = 2'd1; op_slot = 2'd2; op_dst = 8'h00; op_src = 8'hF3;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk("R9", res_data, model(1, 4, 4, 8'h00, 8'hF3));
        op_src = 8'hF3;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R9", res_data, model(1, 1, 3, 8'h00, 8'hF3));
        sh_off[2] = 1; sh_len[2] = 3;
        @(negedge clk);
        chk("R8", W'(res_valid), W'(0));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule